// File: doc/BRIEF.md
# Per-Access Policy Data Cache Controller

This block is a direct-mapped primary data cache that sits between a load/store core and main memory. Every request from the core carries a policy bit. Policy 0 is write-through without write allocation. Policy 1 is write-back with write allocation, and it talks to memory directly with no lower cache level. The block looks up the tag and keeps a valid bit and a dirty bit for each line. It issues whole-line reads for fills, whole-line writes for dirty evictions and single-word writes for write-through traffic.

The core side uses a valid/ready handshake and allows one request in flight at a time. A one-cycle response pulse ends every request. For loads the pulse carries the addressed word. The memory side presents one request at a time and holds it until memory pulses the done strobe for that request kind. All sizes are parameters.

Top module: `dcp_top`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first load to any address needs a line read.
- R2: A load that hits, under either policy, raises `resp_valid` with the addressed word one clock after the accepting edge and causes no memory request.
- R3: A load that misses, under either policy, reads the whole line (`mem_req_kind` 0, line-aligned `mem_addr`), installs it as clean and then answers as a hit.
- R4: A policy-0 store that hits merges into the cached line and issues exactly one word write (`mem_req_kind` 2). The line's dirty bit keeps its previous value, whether that value was clean or dirty.
- R5: A policy-0 store that misses issues only a word write. No line is read or replaced.
- R6: A policy-1 store that hits merges into the line, marks it dirty and causes no memory request.
- R7: A policy-1 store that misses first reads the line from memory, then merges as a hit and marks the line dirty. It never issues a word write.
- R8: When the line being replaced is valid and dirty, its contents are written back with one line write (`mem_req_kind` 1, address built from the old tag and the index) and completed before the line read is issued.
- R9: On stores, only bytes whose `req_be` bit is set change (bit b selects data bits 8b+7..8b). A word write carries the word-aligned address and the same byte enables on `mem_wbe`.
- R10: `req_ready` is 1 only when no request is in progress. A memory request holds its kind and address until the done pulse that matches its kind.

Line data is packed with word w in bits w*DATA_W+DATA_W-1..w*DATA_W. The address splits, from low to high, into byte offset, word select, index and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = store, 0 = load |
| req_mode | input | 1 | Policy: 0 write-through no-allocate, 1 write-back allocate |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load result |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_kind | output | 2 | 0 line read, 1 line write, 2 word write |
| mem_addr | output | ADDR_W | Line-aligned or word-aligned byte address |
| mem_wline | output | DATA_W*WORDS | Line data for a line write |
| mem_wdata | output | DATA_W | Word data for a word write |
| mem_wbe | output | DATA_W/8 | Byte enables for a word write |
| mem_rline | input | DATA_W*WORDS | Line data returned with the read done pulse |
| mem_rd_done | input | 1 | Line read complete |
| mem_wl_done | input | 1 | Line write complete |
| mem_ww_done | input | 1 | Word write complete |

## Verification
The response latency is fixed for every outcome. Count it in rising edges after the accepting edge, with a memory that answers each request on its third cycle. A hit answers after 1 edge. A word write adds 3 edges. A line read adds 4, because the fill first returns to the lookup state. A dirty write-back adds 3 more. The bench samples on falling edges and counts edges until the pulse. It compares that count with the expected latency for each vector, and it compares the number of each memory request kind with the vector's expected counts. Load data is compared against a byte-accurate shadow of every store made.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EVICT,
        ST_FILL,
        ST_WORD
    } dcp_state_e;

    typedef enum logic [1:0] {
        MK_RD_LINE = 2'd0,
        MK_WR_LINE = 2'd1,
        MK_WR_WORD = 2'd2
    } mem_kind_e;

    localparam logic MODE_WT = 1'b0;
    localparam logic MODE_WB = 1'b1;
endpackage

// File: rtl/dcp_merge.sv
module dcp_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic [DATA_W*WORDS-1:0]     line_i,
    input  logic [$clog2(WORDS)-1:0]    wsel,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W/8-1:0]         be,
    output logic [DATA_W*WORDS-1:0]     line_o,
    output logic [DATA_W-1:0]           word_o
);
    localparam int BYTES  = DATA_W / 8;
    localparam int WSEL_W = $clog2(WORDS);

    // byte-lane replacement only in the selected word
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign line_o[w*DATA_W + b*8 +: 8] =
                (wsel == WSEL_W'(w) && be[b]) ? wdata[b*8 +: 8]
                                              : line_i[w*DATA_W + b*8 +: 8];
        end
    end

    assign word_o = line_i[wsel*DATA_W +: DATA_W];
endmodule

// File: rtl/dcp_store.sv
module dcp_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    output logic                     rd_valid,
    output logic                     rd_dirty,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [LINE_W-1:0]        rd_line,
    input  logic                     fill_en,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [LINE_W-1:0]        fill_line,
    input  logic                     upd_en,
    input  logic [LINE_W-1:0]        upd_line,
    input  logic                     upd_set_dirty,
    input  logic                     clean_en
);
    logic [LINES-1:0]  valid_d, valid_q;
    logic [LINES-1:0]  dirty_d, dirty_q;
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] line_d [LINES];
    logic [LINE_W-1:0] line_q [LINES];

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_line  = line_q[idx];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        line_d  = line_q;
        if (fill_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = 1'b0;
            tag_d[idx]   = fill_tag;
            line_d[idx]  = fill_line;
        end else if (upd_en) begin
            line_d[idx] = upd_line;
            if (upd_set_dirty) begin
                dirty_d[idx] = 1'b1;
            end
        end else if (clean_en) begin
            dirty_d[idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '{default: '0};
            line_q  <= '{default: '0};
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            tag_q   <= tag_d;
            line_q  <= line_d;
        end
    end

    // R4
    keep_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !fill_en && !upd_set_dirty) |=> (dirty_q[$past(idx)] == $past(dirty_q[idx])));

    // R3
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));
endmodule

// File: rtl/dcp_top.sv
module dcp_top
    import dcp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_we,
    input  logic                       req_mode,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [DATA_W/8-1:0]        req_be,
    output logic                       resp_valid,
    output logic [DATA_W-1:0]          resp_rdata,
    output logic                       mem_req_valid,
    output logic [1:0]                 mem_req_kind,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W*WORDS-1:0]    mem_wline,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [DATA_W/8-1:0]        mem_wbe,
    input  logic [DATA_W*WORDS-1:0]    mem_rline,
    input  logic                       mem_rd_done,
    input  logic                       mem_wl_done,
    input  logic                       mem_ww_done
);
    localparam int BYTES  = DATA_W / 8;
    localparam int BOFF_W = $clog2(BYTES);
    localparam int WOFF_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int LOW_W  = BOFF_W + WOFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
    localparam int LINE_W = DATA_W * WORDS;
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << BOFF_W) - 1);

    typedef struct packed {
        dcp_state_e          state;
        logic                we;
        logic                mode;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [BYTES-1:0]    be;
        logic                resp_valid;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t d, q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WOFF_W-1:0] wsel;
    logic              st_valid, st_dirty, hit;
    logic [TAG_W-1:0]  st_tag;
    logic [LINE_W-1:0] st_line, merged_line;
    logic [DATA_W-1:0] st_word;
    logic              fill_en, upd_en, upd_set_dirty, clean_en;

    assign idx  = q.addr[LOW_W +: IDX_W];
    assign tag  = q.addr[ADDR_W-1 -: TAG_W];
    assign wsel = q.addr[BOFF_W +: WOFF_W];
    assign hit  = st_valid && (st_tag == tag);

    dcp_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .LINE_W(LINE_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx          (idx),
        .rd_valid     (st_valid),
        .rd_dirty     (st_dirty),
        .rd_tag       (st_tag),
        .rd_line      (st_line),
        .fill_en      (fill_en),
        .fill_tag     (tag),
        .fill_line    (mem_rline),
        .upd_en       (upd_en),
        .upd_line     (merged_line),
        .upd_set_dirty(upd_set_dirty),
        .clean_en     (clean_en)
    );

    dcp_merge #(
        .DATA_W(DATA_W),
        .WORDS (WORDS)
    ) u_merge (
        .line_i(st_line),
        .wsel  (wsel),
        .wdata (q.wdata),
        .be    (q.be),
        .line_o(merged_line),
        .word_o(st_word)
    );

    // next-state
    always_comb begin
        d              = q;
        d.resp_valid   = 1'b0;
        fill_en        = 1'b0;
        upd_en         = 1'b0;
        upd_set_dirty  = 1'b0;
        clean_en       = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_CHECK;
                    d.we    = req_we;
                    d.mode  = req_mode;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.be    = req_be;
                end
            end
            ST_CHECK: begin
                if (hit) begin
                    if (!q.we) begin
                        d.resp_valid = 1'b1;
                        d.rdata      = st_word;
                        d.state      = ST_IDLE;
                    end else begin
                        upd_en        = 1'b1;
                        upd_set_dirty = (q.mode == MODE_WB);
                        if (q.mode == MODE_WB) begin
                            d.resp_valid = 1'b1;
                            d.state      = ST_IDLE;
                        end else begin
                            d.state = ST_WORD;
                        end
                    end
                end else if (q.we && q.mode == MODE_WT) begin
                    d.state = ST_WORD;
                end else if (st_valid && st_dirty) begin
                    d.state = ST_EVICT;
                end else begin
                    d.state = ST_FILL;
                end
            end
            ST_EVICT: begin
                if (mem_wl_done) begin
                    clean_en = 1'b1;
                    d.state  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rd_done) begin
                    fill_en = 1'b1;
                    d.state = ST_CHECK;
                end
            end
            ST_WORD: begin
                if (mem_ww_done) begin
                    d.resp_valid = 1'b1;
                    d.state      = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // memory request decode
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_kind  = MK_RD_LINE;
        mem_addr      = {tag, idx, LOW_W'(0)};
        unique case (q.state)
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_kind  = MK_WR_LINE;
                mem_addr      = {st_tag, idx, LOW_W'(0)};
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                mem_req_kind  = MK_RD_LINE;
            end
            ST_WORD: begin
                mem_req_valid = 1'b1;
                mem_req_kind  = MK_WR_WORD;
                mem_addr      = q.addr & WORD_MASK;
            end
            default: ;
        endcase
    end

    assign mem_wline  = st_line;
    assign mem_wdata  = q.wdata;
    assign mem_wbe    = q.be;
    assign req_ready  = (q.state == ST_IDLE);
    assign resp_valid = q.resp_valid;
    assign resp_rdata = q.rdata;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !(mem_rd_done || mem_wl_done || mem_ww_done))
        |=> (mem_req_valid && $stable(mem_req_kind) && $stable(mem_addr)));

    // R10
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R8
    evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_kind == MK_RD_LINE) |-> !(st_valid && st_dirty));

    // R5
    word_write_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_kind == MK_WR_WORD) |-> (q.we && q.mode == MODE_WT));
endmodule

// File: tb/sim_dcp_top.sv
module sim_dcp_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WN = 4;
    localparam int LW = DW * WN;
    localparam int MEM_LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic          req_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          resp_valid;
    logic [DW-1:0] resp_rdata;
    logic          mem_req_valid;
    logic [1:0]    mem_req_kind;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wline;
    logic [DW-1:0] mem_wdata;
    logic [3:0]    mem_wbe;
    logic [LW-1:0] mem_rline = '0;
    logic          mem_rd_done = 1'b0;
    logic          mem_wl_done = 1'b0;
    logic          mem_ww_done = 1'b0;

    dcp_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_wdata(mem_wdata),
        .mem_wbe(mem_wbe), .mem_rline(mem_rline), .mem_rd_done(mem_rd_done),
        .mem_wl_done(mem_wl_done), .mem_ww_done(mem_ww_done)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] mem    [4096];
    logic [DW-1:0] shadow [4096];
    int cnt_rd = 0, cnt_wl = 0, cnt_ww = 0;
    logic [AW-1:0] last_ww_addr = '0;
    logic [3:0]    last_ww_be = '0;

    // memory model: answers on the MEM_LAT-th falling edge of a request
    initial begin
        int wait_n;
        wait_n = 0;
        for (int i = 0; i < 4096; i++) begin
            mem[i]    = 32'h5A000000 ^ (i * 32'h00010003);
            shadow[i] = mem[i];
        end
        forever begin
            @(negedge clk);
            mem_rd_done = 1'b0;
            mem_wl_done = 1'b0;
            mem_ww_done = 1'b0;
            if (mem_req_valid && rst_n) begin
                wait_n++;
                if (wait_n == MEM_LAT) begin
                    wait_n = 0;
                    case (mem_req_kind)
                        2'd0: begin
                            for (int w = 0; w < WN; w++)
                                mem_rline[w*DW +: DW] = mem[{mem_addr[13:4], 2'(w)}];
                            cnt_rd++;
                            mem_rd_done = 1'b1;
                        end
                        2'd1: begin
                            for (int w = 0; w < WN; w++)
                                mem[{mem_addr[13:4], 2'(w)}] = mem_wline[w*DW +: DW];
                            cnt_wl++;
                            mem_wl_done = 1'b1;
                        end
                        default: begin
                            for (int b = 0; b < 4; b++)
                                if (mem_wbe[b]) mem[mem_addr[13:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                            last_ww_addr = mem_addr;
                            last_ww_be   = mem_wbe;
                            cnt_ww++;
                            mem_ww_done = 1'b1;
                        end
                    endcase
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic we, input logic mode, input logic [AW-1:0] addr,
                           input logic [DW-1:0] wdata, input logic [3:0] be,
                           output logic [DW-1:0] rdata, output int lat, output logic busy_bad);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_mode = mode;
        req_addr = addr; req_wdata = wdata; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        busy_bad = 1'b0;
        while (!resp_valid && lat < 100) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        rdata = resp_rdata;
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) shadow[addr[13:2]][b*8 +: 8] = wdata[b*8 +: 8];
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        mode;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [1:0]  rd;
        logic [1:0]  wl;
        logic [1:0]  ww;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 32'h00000000, 4'h0, 2'd1, 2'd0, 2'd0, 8'd3}, // R3 cold load
        '{1'b0, 1'b0, 16'h0004, 32'h00000000, 4'h0, 2'd0, 2'd0, 2'd0, 8'd2}, // R2 hit
        '{1'b1, 1'b0, 16'h0004, 32'h11223344, 4'hF, 2'd0, 2'd0, 2'd1, 8'd4}, // R4 wt hit
        '{1'b0, 1'b1, 16'h0004, 32'h00000000, 4'h0, 2'd0, 2'd0, 2'd0, 8'd2}, // R2 sees R4 merge
        '{1'b1, 1'b0, 16'h0080, 32'hCAFEF00D, 4'hF, 2'd0, 2'd0, 2'd1, 8'd5}, // R5 wt miss
        '{1'b0, 1'b0, 16'h0080, 32'h00000000, 4'h0, 2'd1, 2'd0, 2'd0, 8'd5}, // R5 no alloc, R4 stayed clean
        '{1'b1, 1'b1, 16'h0088, 32'h0000BEEF, 4'h3, 2'd0, 2'd0, 2'd0, 8'd6}, // R6 wb hit
        '{1'b1, 1'b0, 16'h008C, 32'h77000000, 4'h8, 2'd0, 2'd0, 2'd1, 8'd9}, // R9 byte lane, wt hit on dirty
        '{1'b0, 1'b1, 16'h0000, 32'h00000000, 4'h0, 2'd1, 2'd1, 2'd0, 8'd8}, // R8 dirty kept, evicted
        '{1'b0, 1'b0, 16'h0088, 32'h00000000, 4'h0, 2'd1, 2'd0, 2'd0, 8'd8}, // R8 data reached memory
        '{1'b1, 1'b1, 16'h0114, 32'h00AB0000, 4'h4, 2'd1, 2'd0, 2'd0, 8'd7}, // R7 wb miss allocate
        '{1'b0, 1'b0, 16'h0014, 32'h00000000, 4'h0, 2'd1, 2'd1, 2'd0, 8'd8}, // R8 evict allocated line
        '{1'b0, 1'b1, 16'h0114, 32'h00000000, 4'h0, 2'd1, 2'd0, 2'd0, 8'd9}, // R9 single byte merged
        '{1'b1, 1'b1, 16'h0020, 32'hDEADBEEF, 4'hF, 2'd1, 2'd0, 2'd0, 8'd7}, // R7
        '{1'b1, 1'b1, 16'h0024, 32'h01020304, 4'hF, 2'd0, 2'd0, 2'd0, 8'd6}, // R6
        '{1'b0, 1'b1, 16'h0020, 32'h00000000, 4'h0, 2'd0, 2'd0, 2'd0, 8'd2}  // R2
    };

    initial begin
        logic [DW-1:0] rd;
        int lat;
        logic busy_bad;
        int rd0, wl0, ww0;
        string tg;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 resp", 32'(resp_valid), 32'd0);
        chk("R1 memreq", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
            rd0 = cnt_rd; wl0 = cnt_wl; ww0 = cnt_ww;
            run_req(VECS[v].we, VECS[v].mode, VECS[v].addr, VECS[v].wdata, VECS[v].be,
                    rd, lat, busy_bad);
            chk({tg, " reads"},  32'(cnt_rd - rd0), 32'(VECS[v].rd));
            chk({tg, " lwrites"}, 32'(cnt_wl - wl0), 32'(VECS[v].wl));
            chk({tg, " wwrites"}, 32'(cnt_ww - ww0), 32'(VECS[v].ww));
            chk({tg, " latency"}, 32'(lat),
                32'(1 + 4*VECS[v].rd + 3*VECS[v].wl + 3*VECS[v].ww));
            chk({tg, " R10 ready low while busy"}, 32'(busy_bad), 32'd0);
            if (!VECS[v].we)
                chk({tg, " rdata"}, rd, shadow[VECS[v].addr[13:2]]);
            if (VECS[v].ww != 0)
                chk({tg, " R4 memory word"}, mem[VECS[v].addr[13:2]], shadow[VECS[v].addr[13:2]]);
        end

        // R9 word write carries aligned address and the same enables
        run_req(1'b1, 1'b0, 16'h0026, 32'h00990000, 4'b0100, rd, lat, busy_bad);
        chk("R9 ww addr", 32'(last_ww_addr), 32'h0024);
        chk("R9 ww be", 32'(last_ww_be), 32'h4);
        run_req(1'b0, 1'b1, 16'h0024, 32'h0, 4'h0, rd, lat, busy_bad);
        chk("R9 cached merge", rd, shadow[16'h0024 >> 2]);
        chk("R2 hit latency", 32'(lat), 32'd1);

        // R1 reset invalidates all lines
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 memreq after reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        rd0 = cnt_rd;
        run_req(1'b0, 1'b0, 16'h0004, 32'h0, 4'h0, rd, lat, busy_bad);
        chk("R1 line invalid after reset", 32'(cnt_rd - rd0), 32'd1);
        chk("R3 data after reset", rd, shadow[1]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule